// File: doc/BRIEF.md
# Program Counter and Branch Unit

This unit owns the 12-bit program counter and the 16-bit return-stack pointer of a small 8-bit register machine. The instruction decoder hands it the fields of each instruction together with an `issue` strobe. The unit then carries out the control-flow instructions: absolute jump, indexed jump, call, return, the register and immediate compare skips, and the key-state skips. Every result is relative to the pc of the instruction being executed. The ordinary advance to the next instruction comes from the fetch logic through `pc_step`. A skip adds a further 2 to the pc.

Call and return exchange one 16-bit word with memory. The stack grows downward: a call writes the current pc at the stack pointer and then lowers the pointer by 2, so the saved word sits at sp+2 once the call is over. A return reads the word at sp+2 and raises the pointer by 2. The unit selects its own register-file read ports; the data must come back in the same cycle. Encodings that are reserved in the groups this unit decodes raise a one-cycle error strobe and change nothing.

Top module: `pc_branch_unit`

## Requirements
- R1: After reset, pc equals RESET_PC, sp equals SP_RESET, and busy, err and mem_req are all 0.
- R2: Opcode 0x1aaa sets pc to aaa on the clock edge that samples issue.
- R3: Opcode 0x2aaa writes the word {4'h0, pc} to address sp. When mem_ready completes the write, pc becomes aaa and sp becomes sp-2, so the saved word is found at the new sp+2.
- R4: Opcode 0x00EE reads the word at address sp+2. When mem_ready completes the read, pc takes bits 11:0 of that word and sp becomes sp+2.
- R5: Opcode 0x3Xbb adds 2 to pc when vX equals bb. Opcode 0x4Xbb adds 2 to pc when vX differs from bb. Otherwise pc is unchanged.
- R6: Opcode 0x5XY0 adds 2 to pc when vX equals vY. Opcode 0x9XY0 adds 2 to pc when vX differs from vY.
- R7: Opcode 0xEX9E adds 2 to pc when keys[vX[3:0]] is 1. Opcode 0xEXA1 adds 2 to pc when that key bit is 0.
- R8: Opcode 0xBnnn sets pc to (nnn + v0) mod 4096 when idx_quirk is 0. When idx_quirk is 1, the added register is v[nnn[11:8]].
- R9: The encodings 0x5XYn and 0x9XYn with n not 0, 0x8XYF, 0xEX0F and 0xFX0F pulse err high for exactly the one cycle after the issuing edge, and leave pc and sp unchanged.
- R10: During a call or a return, busy is 1 and mem_req is held with stable mem_addr, mem_we and mem_wdata until mem_ready. Any issue or pc_step seen while busy is ignored.
- R11: pc_step with no issue and busy 0 adds 2 to pc, wrapping modulo 4096.
- R12: The stack pointer wraps modulo 65536 in both directions: a return at sp=0xFFFE reads address 0x0000 and leaves sp=0x0000.
- R13: Opcodes outside the control-flow set, such as 0x00E0, 0x6Xbb, 0x8XY4 and 0xEXFF, leave pc and sp unchanged and do not raise err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| issue | input | 1 | Instruction fields are valid this cycle |
| op_hi | input | 4 | Opcode bits 15:12 |
| op_x | input | 4 | Opcode bits 11:8 |
| op_y | input | 4 | Opcode bits 7:4 |
| op_n | input | 4 | Opcode bits 3:0 |
| op_imm | input | 8 | Opcode bits 7:0 |
| op_addr | input | 12 | Opcode bits 11:0 |
| idx_quirk | input | 1 | Indexed jump takes its offset register from target bits 11:8 |
| pc_step | input | 1 | Normal +2 advance from fetch |
| reg_x_sel | output | 4 | Register index for read port X |
| reg_x_data | input | 8 | Read data for port X, same cycle |
| reg_y_sel | output | 4 | Register index for read port Y |
| reg_y_data | input | 8 | Read data for port Y, same cycle |
| keys | input | 16 | Key pressed state, one bit per key |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | 1 for a write (push), 0 for a read (pop) |
| mem_addr | output | 16 | Word byte address |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid with mem_ready |
| mem_ready | input | 1 | Completes the request in this cycle |
| pc | output | 12 | Program counter |
| sp | output | 16 | Stack pointer |
| busy | output | 1 | A stack transfer is in progress |
| err | output | 1 | Illegal-encoding strobe |

## Verification
The hardest case to reach from the ports is the wrap of the stack pointer through zero. The unit cannot load sp directly, so the bench builds the unit with SP_RESET at 0xFFFE and places a known word at memory address 0. It then issues more returns than calls, which moves sp across the boundary, and follows with a call that must write at address 0 and bring sp back to 0xFFFE. The bench also issues a jump while a call is still waiting for mem_ready. This checks that a busy unit drops the instruction and not the stack transfer.

// File: rtl/bru_pkg.sv
// Shared types for the program counter and branch unit.
// Assumes nothing beyond IEEE 1800-2017 enums.
package bru_pkg;

    // Class of operation the decoder assigns to one instruction
    typedef enum logic [2:0] {
        BR_NONE,
        BR_JUMP,
        BR_CALL,
        BR_RET,
        BR_SKIP,
        BR_JIDX,
        BR_BAD
    } br_kind_t;

    // Condition a skip instruction tests
    typedef enum logic [2:0] {
        C_IMM_EQ,
        C_IMM_NE,
        C_REG_EQ,
        C_REG_NE,
        C_KEY_DN,
        C_KEY_UP
    } br_cond_t;

    // Stack transfer sequencer state
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PUSH,
        ST_POP
    } stk_state_t;

endpackage

// File: rtl/bru_decode.sv
// Instruction classifier for the branch unit.
// Purely combinational: it maps the instruction fields to an operation
// class and a skip condition, and picks the register read indices.
// Assumes the fields all come from the same 16-bit instruction word.
module bru_decode
    import bru_pkg::*;
#(
    parameter int NIB_W  = 4,
    parameter int IMM_W  = 8,
    parameter int ADDR_W = 12
) (
    input  logic [NIB_W-1:0]  op_hi,
    input  logic [NIB_W-1:0]  op_x,
    input  logic [NIB_W-1:0]  op_y,
    input  logic [NIB_W-1:0]  op_n,
    input  logic [IMM_W-1:0]  op_imm,
    input  logic [ADDR_W-1:0] op_addr,
    input  logic              idx_quirk,
    output br_kind_t          kind,
    output br_cond_t          cond,
    output logic [NIB_W-1:0]  x_sel,
    output logic [NIB_W-1:0]  y_sel
);

    localparam logic [NIB_W-1:0] NIB_ZERO = '0;
    localparam logic [NIB_W-1:0] NIB_FULL = '1;

    // Classify the instruction by its top nibble and sub-fields
    always_comb begin
        kind = BR_NONE;
        cond = C_IMM_EQ;
        unique case (op_hi)
            4'h0: if (op_x == NIB_ZERO && op_imm == 8'hEE) kind = BR_RET;
            4'h1: kind = BR_JUMP;
            4'h2: kind = BR_CALL;
            4'h3: begin kind = BR_SKIP; cond = C_IMM_EQ; end
            4'h4: begin kind = BR_SKIP; cond = C_IMM_NE; end
            4'h5: begin
                kind = (op_n == NIB_ZERO) ? BR_SKIP : BR_BAD;
                cond = C_REG_EQ;
            end
            4'h8: if (op_n == NIB_FULL) kind = BR_BAD;
            4'h9: begin
                kind = (op_n == NIB_ZERO) ? BR_SKIP : BR_BAD;
                cond = C_REG_NE;
            end
            4'hB: kind = BR_JIDX;
            4'hE: begin
                if (op_imm == 8'h9E) begin kind = BR_SKIP; cond = C_KEY_DN; end
                else if (op_imm == 8'hA1) begin kind = BR_SKIP; cond = C_KEY_UP; end
                else if (op_imm == 8'h0F) kind = BR_BAD;
            end
            4'hF: if (op_imm == 8'h0F) kind = BR_BAD;
            default: kind = BR_NONE;
        endcase
    end

    // Read port X serves vX, or the offset register of an indexed jump
    always_comb begin
        if (kind == BR_JIDX)
            x_sel = idx_quirk ? op_addr[ADDR_W-1 -: NIB_W] : NIB_ZERO;
        else
            x_sel = op_x;
        y_sel = op_y;
    end

endmodule

// File: rtl/bru_cond.sv
// Skip-condition evaluator.
// Combinational: it compares register data against the immediate or the
// second register, or looks up a key bit indexed by the low bits of vX.
module bru_cond
    import bru_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int NKEY   = 16
) (
    input  br_cond_t          cond,
    input  logic [DATA_W-1:0] x_data,
    input  logic [DATA_W-1:0] y_data,
    input  logic [DATA_W-1:0] imm,
    input  logic [NKEY-1:0]   keys,
    output logic              take
);

    localparam int KEY_IDX_W = $clog2(NKEY);

    logic key_hit;

    // Key state for the key numbered by the low bits of vX
    always_comb key_hit = keys[x_data[KEY_IDX_W-1:0]];

    // Decide whether the skip is taken
    always_comb begin
        unique case (cond)
            C_IMM_EQ: take = (x_data == imm);
            C_IMM_NE: take = (x_data != imm);
            C_REG_EQ: take = (x_data == y_data);
            C_REG_NE: take = (x_data != y_data);
            C_KEY_DN: take = key_hit;
            C_KEY_UP: take = !key_hit;
            default:  take = 1'b0;
        endcase
    end

endmodule

// File: rtl/bru_stack.sv
// Return-stack sequencer with its stack pointer.
// A push writes the current pc at sp and then lowers sp by 2. A pop reads
// at sp+2 and then raises sp by 2. Both hold the request until ready.
// Assumes cur_pc stays stable while busy and WORD_W >= PC_W.
module bru_stack
    import bru_pkg::*;
#(
    parameter int          PC_W     = 12,
    parameter int          SP_W     = 16,
    parameter int          WORD_W   = 16,
    parameter logic [15:0] SP_RESET = 16'h0EA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_go,
    input  logic              pop_go,
    input  logic [PC_W-1:0]   cur_pc,
    input  logic [PC_W-1:0]   target,
    output logic              mem_req,
    output logic              mem_we,
    output logic [SP_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [SP_W-1:0]   sp,
    output logic              busy,
    output logic              load_en,
    output logic [PC_W-1:0]   load_pc
);

    localparam logic [SP_W-1:0] SP_STEP = SP_W'(2);

    stk_state_t      state_q;
    logic [PC_W-1:0] target_q;
    logic [SP_W-1:0] sp_q;

    // Sequence one push or pop and move the stack pointer on completion
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            target_q <= '0;
            sp_q     <= SP_W'(SP_RESET);
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (push_go) begin
                        state_q  <= ST_PUSH;
                        target_q <= target;
                    end else if (pop_go) begin
                        state_q <= ST_POP;
                    end
                end
                ST_PUSH: if (mem_ready) begin
                    sp_q    <= sp_q - SP_STEP;
                    state_q <= ST_IDLE;
                end
                ST_POP: if (mem_ready) begin
                    sp_q    <= sp_q + SP_STEP;
                    state_q <= ST_IDLE;
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // Drive the memory port and the pc load from the current state
    always_comb begin
        mem_req   = (state_q != ST_IDLE);
        mem_we    = (state_q == ST_PUSH);
        mem_addr  = (state_q == ST_PUSH) ? sp_q : sp_q + SP_STEP;
        mem_wdata = WORD_W'(cur_pc);
        load_en   = mem_req && mem_ready;
        load_pc   = (state_q == ST_PUSH) ? target_q : mem_rdata[PC_W-1:0];
        busy      = mem_req;
        sp        = sp_q;
    end

endmodule

// File: rtl/pc_branch_unit.sv
// Program counter and branch unit, top level.
// Holds the pc and applies jumps, skips, the indexed jump and the results
// of call and return. Assumes register read data returns in the same cycle
// and that fetch asserts pc_step for the normal +2 advance.
module pc_branch_unit
    import bru_pkg::*;
#(
    parameter int          PC_W     = 12,
    parameter int          SP_W     = 16,
    parameter int          WORD_W   = 16,
    parameter int          DATA_W   = 8,
    parameter int          NKEY     = 16,
    parameter logic [11:0] RESET_PC = 12'h200,
    parameter logic [15:0] SP_RESET = 16'h0EA0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              issue,
    input  logic [3:0]        op_hi,
    input  logic [3:0]        op_x,
    input  logic [3:0]        op_y,
    input  logic [3:0]        op_n,
    input  logic [7:0]        op_imm,
    input  logic [PC_W-1:0]   op_addr,
    input  logic              idx_quirk,
    input  logic              pc_step,
    output logic [3:0]        reg_x_sel,
    input  logic [DATA_W-1:0] reg_x_data,
    output logic [3:0]        reg_y_sel,
    input  logic [DATA_W-1:0] reg_y_data,
    input  logic [NKEY-1:0]   keys,
    output logic              mem_req,
    output logic              mem_we,
    output logic [SP_W-1:0]   mem_addr,
    output logic [WORD_W-1:0] mem_wdata,
    input  logic [WORD_W-1:0] mem_rdata,
    input  logic              mem_ready,
    output logic [PC_W-1:0]   pc,
    output logic [SP_W-1:0]   sp,
    output logic              busy,
    output logic              err
);

    localparam logic [PC_W-1:0] PC_STEP = PC_W'(2);

    br_kind_t        kind;
    br_cond_t        cond;
    logic            take;
    logic            accept;
    logic            stk_load;
    logic [PC_W-1:0] stk_pc;
    logic [PC_W-1:0] pc_q;
    logic            err_q;

    bru_decode #(.NIB_W(4), .IMM_W(8), .ADDR_W(PC_W)) u_dec (
        .op_hi(op_hi), .op_x(op_x), .op_y(op_y), .op_n(op_n),
        .op_imm(op_imm), .op_addr(op_addr), .idx_quirk(idx_quirk),
        .kind(kind), .cond(cond), .x_sel(reg_x_sel), .y_sel(reg_y_sel)
    );

    bru_cond #(.DATA_W(DATA_W), .NKEY(NKEY)) u_cond (
        .cond(cond), .x_data(reg_x_data), .y_data(reg_y_data),
        .imm(DATA_W'(op_imm)), .keys(keys), .take(take)
    );

    // An instruction is only taken while no stack transfer is running
    always_comb accept = issue && !busy;

    bru_stack #(.PC_W(PC_W), .SP_W(SP_W), .WORD_W(WORD_W), .SP_RESET(SP_RESET)) u_stk (
        .clk(clk), .rst_n(rst_n),
        .push_go(accept && kind == BR_CALL),
        .pop_go(accept && kind == BR_RET),
        .cur_pc(pc_q), .target(op_addr),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .sp(sp), .busy(busy), .load_en(stk_load), .load_pc(stk_pc)
    );

    // Update the pc from stack results, branch instructions or the fetch step
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= PC_W'(RESET_PC);
        end else if (stk_load) begin
            pc_q <= stk_pc;
        end else if (accept) begin
            unique case (kind)
                BR_JUMP: pc_q <= op_addr;
                BR_SKIP: if (take) pc_q <= pc_q + PC_STEP;
                BR_JIDX: pc_q <= op_addr + PC_W'(reg_x_data);
                default: pc_q <= pc_q;
            endcase
        end else if (pc_step && !busy) begin
            pc_q <= pc_q + PC_STEP;
        end
    end

    // One-cycle strobe for an illegal encoding
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= accept && (kind == BR_BAD);
    end

    assign pc  = pc_q;
    assign err = err_q;

endmodule

// File: rtl/pc_branch_unit_sva.sv
// Property checker for pc_branch_unit, bound to every instance.
// Watches only the top-level ports.
module pc_branch_unit_sva #(
    parameter int PC_W   = 12,
    parameter int SP_W   = 16,
    parameter int WORD_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_req,
    input logic              mem_we,
    input logic [SP_W-1:0]   mem_addr,
    input logic [WORD_W-1:0] mem_wdata,
    input logic [WORD_W-1:0] mem_rdata,
    input logic              mem_ready,
    input logic [PC_W-1:0]   pc,
    input logic [SP_W-1:0]   sp,
    input logic              busy,
    input logic              err
);

    AST_BAD_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (pc == $past(pc)) && (sp == $past(sp)));                             // R9

    AST_PUSH_AT_SP: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_we) |-> (mem_addr == sp));                                  // R3

    AST_PUSH_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && mem_we) |=> (sp == $past(sp) - SP_W'(2)));          // R3

    AST_POP_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && mem_ready && !mem_we) |=>
            (sp == $past(sp) + SP_W'(2)) && (pc == $past(mem_rdata[PC_W-1:0])));    // R4

    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=>
            mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R10

    AST_PC_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !mem_ready) |=> $stable(pc));                                      // R10

    AST_REQ_IS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> busy);                                                          // R10

endmodule

bind pc_branch_unit pc_branch_unit_sva #(.PC_W(PC_W), .SP_W(SP_W), .WORD_W(WORD_W)) u_sva (
    .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .mem_ready(mem_ready), .pc(pc), .sp(sp), .busy(busy), .err(err)
);

// File: tb/pc_branch_unit_test.sv
// Directed bench for pc_branch_unit: one task per scenario.
module pc_branch_unit_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        issue = 1'b0;
    logic [15:0] word = 16'h0000;
    logic        idx_quirk = 1'b0;
    logic        pc_step = 1'b0;
    logic [3:0]  reg_x_sel, reg_y_sel;
    logic [7:0]  reg_x_data, reg_y_data;
    logic [15:0] keys = 16'h0000;
    logic        mem_req, mem_we;
    logic [15:0] mem_addr, mem_wdata, mem_rdata;
    logic        mem_ready = 1'b0;
    logic [11:0] pc;
    logic [15:0] sp;
    logic        busy, err;

    logic [7:0]  rf [16];
    logic [15:0] bmem [16];

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    pc_branch_unit #(.RESET_PC(12'h200), .SP_RESET(16'hFFFE)) uut (
        .clk(clk), .rst_n(rst_n), .issue(issue),
        .op_hi(word[15:12]), .op_x(word[11:8]), .op_y(word[7:4]), .op_n(word[3:0]),
        .op_imm(word[7:0]), .op_addr(word[11:0]), .idx_quirk(idx_quirk),
        .pc_step(pc_step), .reg_x_sel(reg_x_sel), .reg_x_data(reg_x_data),
        .reg_y_sel(reg_y_sel), .reg_y_data(reg_y_data), .keys(keys),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready),
        .pc(pc), .sp(sp), .busy(busy), .err(err)
    );

    assign reg_x_data = rf[reg_x_sel];
    assign reg_y_data = rf[reg_y_sel];
    assign mem_rdata  = bmem[mem_addr[4:1]];

    // Memory model: ready one cycle after the request appears
    always @(posedge clk) begin
        mem_ready <= rst_n && mem_req && !mem_ready;
        if (mem_req && mem_ready && mem_we) bmem[mem_addr[4:1]] <= mem_wdata;
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run(input logic [15:0] w);
        @(negedge clk);
        word  = w;
        issue = 1'b1;
        @(negedge clk);
        issue = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 20 && busy; i++) @(negedge clk);
    endtask

    task automatic t_reset();
        check("R1 pc", 32'(pc), 32'h200);
        check("R1 sp", 32'(sp), 32'hFFFE);
        check("R1 busy/err/req", {busy, err, mem_req}, 32'h0);
    endtask

    task automatic t_jump_step();
        run(16'h1ABC); check("R2 jump", 32'(pc), 32'hABC);
        run(16'h1300); check("R2 jump", 32'(pc), 32'h300);
        pc_step = 1'b1; @(negedge clk); pc_step = 1'b0;
        check("R11 step", 32'(pc), 32'h302);
        run(16'h1FFE);
        pc_step = 1'b1; @(negedge clk); pc_step = 1'b0;
        check("R11 step wrap", 32'(pc), 32'h000);
    endtask

    task automatic t_imm_skip();
        run(16'h1300);
        run(16'h335A); check("R5 eq taken", 32'(pc), 32'h302);
        run(16'h435A); check("R5 ne not taken", 32'(pc), 32'h302);
        run(16'h3359); check("R5 eq not taken", 32'(pc), 32'h302);
        run(16'h4359); check("R5 ne taken", 32'(pc), 32'h304);
    endtask

    task automatic t_reg_skip();
        run(16'h1300);
        run(16'h5340); check("R6 eq taken", 32'(pc), 32'h302);
        run(16'h5350); check("R6 eq not taken", 32'(pc), 32'h302);
        run(16'h9350); check("R6 ne taken", 32'(pc), 32'h304);
        run(16'h9340); check("R6 ne not taken", 32'(pc), 32'h304);
    endtask

    task automatic t_key_skip();
        run(16'h1300);
        keys = 16'h0080;
        run(16'hE69E); check("R7 down taken", 32'(pc), 32'h302);
        run(16'hE6A1); check("R7 up not taken", 32'(pc), 32'h302);
        keys = 16'hFF7F;
        run(16'hE69E); check("R7 down not taken", 32'(pc), 32'h302);
        run(16'hE6A1); check("R7 up taken", 32'(pc), 32'h304);
        keys = 16'h0000;
    endtask

    task automatic t_jidx();
        idx_quirk = 1'b0;
        run(16'hBA20); check("R8 quirk off", 32'(pc), 32'hA30);
        run(16'hBFF8); check("R8 wrap", 32'(pc), 32'h008);
        idx_quirk = 1'b1;
        run(16'hBA20); check("R8 quirk on", 32'(pc), 32'hB15);
        idx_quirk = 1'b0;
    endtask

    task automatic t_illegal();
        logic [15:0] bad [5] = '{16'h5341, 16'h934F, 16'h8ABF, 16'hE30F, 16'hF10F};
        run(16'h1300);
        foreach (bad[i]) begin
            run(bad[i]);
            check("R9 err strobe", 32'(err), 32'h1);
            check("R9 pc kept", 32'(pc), 32'h300);
            check("R9 sp kept", 32'(sp), 32'hFFFE);
            @(negedge clk);
            check("R9 err one cycle", 32'(err), 32'h0);
        end
    endtask

    task automatic t_no_effect();
        logic [15:0] other [4] = '{16'h00E0, 16'h6A55, 16'h8AB4, 16'hE3FF};
        run(16'h1300);
        foreach (other[i]) begin
            run(other[i]);
            check("R13 pc", 32'(pc), 32'h300);
            check("R13 err", 32'(err), 32'h0);
        end
        check("R13 sp", 32'(sp), 32'hFFFE);
    endtask

    task automatic t_call_ret();
        run(16'h1300);
        run(16'h2456);
        check("R10 busy", 32'(busy), 32'h1);
        check("R3 write req", {mem_req, mem_we, mem_addr}, {16'h0003, 16'hFFFE});
        check("R3 write data", 32'(mem_wdata), 32'h0300);
        run(16'h1777);
        wait_idle();
        check("R10 jump ignored, R3 pc", 32'(pc), 32'h456);
        check("R3 sp", 32'(sp), 32'hFFFC);
        check("R3 saved at sp+2", 32'(bmem[4'hF]), 32'h0300);
        run(16'h2500); wait_idle();
        check("R3 nested pc", 32'(pc), 32'h500);
        check("R3 nested saved", 32'(bmem[4'hE]), 32'h0456);
        run(16'h00EE);
        check("R4 read req", {mem_req, mem_we, mem_addr}, {16'h0002, 16'hFFFC});
        wait_idle();
        check("R4 pc", 32'(pc), 32'h456);
        check("R4 sp", 32'(sp), 32'hFFFC);
        run(16'h00EE); wait_idle();
        check("R4 pc outer", 32'(pc), 32'h300);
        check("R4 sp outer", 32'(sp), 32'hFFFE);
    endtask

    task automatic t_sp_wrap();
        run(16'h00EE);
        check("R12 read at 0", 32'(mem_addr), 32'h0000);
        wait_idle();
        check("R12 pc", 32'(pc), 32'hABC);
        check("R12 sp wraps up", 32'(sp), 32'h0000);
        run(16'h2123); wait_idle();
        check("R12 sp wraps down", 32'(sp), 32'hFFFE);
        check("R12 saved at 0", 32'(bmem[0]), 32'h0ABC);
        check("R12 call pc", 32'(pc), 32'h123);
    endtask

    initial begin
        for (int i = 0; i < 16; i++) begin
            rf[i]   = 8'(i * 3);
            bmem[i] = 16'h0000;
        end
        rf[0] = 8'h10; rf[3] = 8'h5A; rf[4] = 8'h5A; rf[5] = 8'h11;
        rf[6] = 8'h27; rf[4'hA] = 8'hF5;
        bmem[0] = 16'h0ABC;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_jump_step();
        t_imm_skip();
        t_reg_skip();
        t_key_skip();
        t_jidx();
        t_illegal();
        t_no_effect();
        t_call_ret();
        t_sp_wrap();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule